// File: doc/BRIEF.md
# Periodic battery test scheduler

This controller decides when a backup battery is put under a test load, and it holds a latched warning when the battery reads low. While main power is good it counts a long interval. When the interval ends it turns on a test load for a short, fixed window. During that window it watches a digitized comparator flag that goes high when the battery is below its trip level. A test also runs after every power-up, once the supervisor reports that recovery is complete.

The warning is latched. A later periodic test does not clear it, even if that test passes. Only a passing power-up test clears it. While power is bad, the load is off, no test is scheduled and the warning is frozen. If power fails during a test, that test is thrown away.

The interval length and the window length are parameters counted in clock cycles. A real design can set them to full-scale values, and a simulation can use short ones. The analog load and the comparator are outside the block.

Top module: `battery_test_sched`

## Requirements
- R1: On the first clock edge that samples pwr_good_i and recov_done_i both high while the block is unpowered, a power-up test starts, and load_en_o is high from that edge on. This happens whether or not the warning is active.
- R2: No test starts while recov_done_i is low after power returns. Once powered operation has begun, recov_done_i has no effect on the schedule.
- R3: load_en_o stays high for exactly WINDOW_CYC consecutive cycles per completed test. The comparator flag is sampled on each of those WINDOW_CYC edges.
- R4: After each completed test, load_en_o stays low for exactly INTERVAL_CYC cycles and then a periodic test starts. The interval count restarts at every power-up.
- R5: If below_trip_i is sampled high on any edge of a test window, the warning is asserted on the edge that ends the window. A high flag outside the window has no effect. batt_warn_pull_o is an open-drain drive: 1 sinks the line (warning asserted) and 0 releases it.
- R6: A periodic test that passes leaves an asserted warning asserted.
- R7: A power-up test sets the warning to its own result: it clears the warning on a pass and asserts it on a fail.
- R8: While pwr_good_i is low, load_en_o is low in the same cycle, no test starts and the warning does not change. A test cut short by a power failure leaves the warning unchanged.
- R9: Under reset, load_en_o is low and the warning is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Main supply within tolerance |
| recov_done_i | input | 1 | Power-up recovery time has elapsed |
| below_trip_i | input | 1 | Battery below trip level, from the comparator |
| load_en_o | output | 1 | Connect the battery test load |
| batt_warn_pull_o | output | 1 | Open-drain warning drive, 1 = sink |

## Verification
The results fall due at these points:
- **Test start:** load_en_o rises one edge after pwr_good_i and recov_done_i are sampled together, or INTERVAL_CYC edges after the previous window closed.
- **Window end:** load_en_o falls WINDOW_CYC edges after it rose, and the warning changes on that same edge.
- **Power loss:** load_en_o drops combinationally in the cycle pwr_good_i falls.

The bench drives and samples on the falling clock edge. It counts falling edges while waiting for each transition, so every length is measured against these counts. Each comparator pulse is placed at a known window index or just outside the window.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_PUP  = 2'd1,
    ST_IDLE = 2'd2,
    ST_PER  = 2'd3
  } bts_state_e;
endpackage

// File: rtl/bts_counter.sv
module bts_counter #(
  parameter int unsigned LIMIT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign last_o = en_i && (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || last_o)   cnt_q <= '0;
    else if (en_i)              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bts_fsm.sv
module bts_fsm
  import bts_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_good_i,
  input  logic       recov_done_i,
  input  logic       win_last_i,
  input  logic       ivl_last_i,
  output bts_state_e state_o
);
  bts_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:  if (pwr_good_i && recov_done_i) state_d = ST_PUP;
      ST_PUP,
      ST_PER: begin
        if (!pwr_good_i)     state_d = ST_OFF;
        else if (win_last_i) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (!pwr_good_i)     state_d = ST_OFF;
        else if (ivl_last_i) state_d = ST_PER;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bts_verdict.sv
module bts_verdict (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic below_i,
  input  logic commit_i,
  input  logic pup_i,
  output logic warn_o
);
  logic fail_q, warn_q, result;

  assign result = fail_q | below_i;

  // accumulator discarded whenever no test is live (incl. power abort)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    fail_q <= 1'b0;
    else if (!sample_i || commit_i) fail_q <= 1'b0;
    else if (below_i)               fail_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       warn_q <= 1'b0;
    else if (commit_i) warn_q <= pup_i ? result : (warn_q | result);
  end

  assign warn_o = warn_q;
endmodule

// File: rtl/battery_test_sched.sv
module battery_test_sched
  import bts_pkg::*;
#(
  parameter int unsigned INTERVAL_CYC = 86400,
  parameter int unsigned WINDOW_CYC   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic recov_done_i,
  input  logic below_trip_i,
  output logic load_en_o,
  output logic batt_warn_pull_o
);
  bts_state_e state;
  logic in_test, in_idle, win_last, ivl_last, sample;

  assign in_test = (state == ST_PUP) || (state == ST_PER);
  assign in_idle = (state == ST_IDLE);
  assign sample  = in_test && pwr_good_i;

  bts_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwr_good_i   (pwr_good_i),
    .recov_done_i (recov_done_i),
    .win_last_i   (win_last),
    .ivl_last_i   (ivl_last),
    .state_o      (state)
  );

  bts_counter #(.LIMIT(WINDOW_CYC)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_test),
    .en_i   (sample),
    .last_o (win_last)
  );

  bts_counter #(.LIMIT(INTERVAL_CYC)) u_ivl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_idle),
    .en_i   (in_idle && pwr_good_i),
    .last_o (ivl_last)
  );

  bts_verdict u_verdict (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample),
    .below_i  (below_trip_i),
    .commit_i (sample && win_last),
    .pup_i    (state == ST_PUP),
    .warn_o   (batt_warn_pull_o)
  );

  // load drops in the same cycle power is lost
  assign load_en_o = sample;
endmodule

// File: rtl/bts_chk.sv
module bts_chk
  import bts_pkg::*;
#(
  parameter int unsigned WINDOW = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_good_i,
  input logic       load_en_o,
  input logic       warn_i,
  input bts_state_e state_i
);
  logic [31:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt_q <= '0;
    else if (load_en_o) hi_cnt_q <= hi_cnt_q + 1;
    else                hi_cnt_q <= '0;
  end

  // R3
  win_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_o |-> (hi_cnt_q < WINDOW));

  // R1
  start_needs_power_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_en_o) |-> $past(pwr_good_i));

  // R8
  warn_frozen_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> $stable(warn_i));

  // R5
  warn_at_window_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(warn_i) |-> $fell(load_en_o));

  // R6
  periodic_no_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PER && warn_i) |=> warn_i);

  // R7
  clear_only_pup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(warn_i) |-> ($past(state_i) == ST_PUP));
endmodule

bind battery_test_sched bts_chk #(.WINDOW(WINDOW_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_good_i (pwr_good_i),
  .load_en_o  (load_en_o),
  .warn_i     (batt_warn_pull_o),
  .state_i    (state)
);

// File: tb/sim_battery_test_sched.sv
module sim_battery_test_sched;
  localparam int IVL = 20;
  localparam int WIN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b0, rd = 1'b0, bt = 1'b0;
  logic load_en, warn;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  battery_test_sched #(.INTERVAL_CYC(IVL), .WINDOW_CYC(WIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .recov_done_i(rd),
    .below_trip_i(bt), .load_en_o(load_en), .batt_warn_pull_o(warn)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // falling edges until load_en is seen high
  task automatic count_low(output int n);
    n = 0;
    while (!load_en && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  // called where load_en was first seen high; mask[i] drives window edge i
  task automatic run_window(input logic [3:0] mask, output int len);
    len = 0;
    while (load_en && len < 64) begin
      bt = (len < WIN) ? mask[len[1:0]] : 1'b0;
      @(negedge clk);
      len++;
    end
    bt = 1'b0;
  endtask

  task automatic power_cycle();
    pg = 1'b0;
    cycles(2);
    pg = 1'b1;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (cyc > 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
      finish_run();
    end
  end

  initial begin
    int n, len, hi;
    cycles(3);
    chk("R9 load in reset", load_en, 0);
    chk("R9 warn in reset", warn, 0);
    rst_n = 1'b1;
    cycles(2);

    // powered, recovery pending
    pg = 1'b1;
    hi = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); hi += load_en; end
    chk("R2 no test before recovery", hi, 0);
    rd = 1'b1;
    count_low(n);
    chk("R1 power-up test start", n, 1);
    run_window(4'b0000, len);
    chk("R3 window length", len, WIN);
    chk("R7 pass clears", warn, 0);

    // recovery input ignored once running
    rd = 1'b0;
    count_low(n);
    chk("R4 interval after power-up", n, IVL);
    chk("R2 recov ignored when running", n, IVL);
    rd = 1'b1;
    run_window(4'b0000, len);
    chk("R3 periodic window length", len, WIN);
    count_low(n);
    chk("R4 periodic interval", n, IVL);

    // abort mid-test with a low reading
    bt = 1'b1;
    @(negedge clk);
    bt = 1'b0;
    pg = 1'b0;
    #1;
    chk("R8 load drops with power", load_en, 0);
    hi = 0;
    for (int i = 0; i < 2 * IVL; i++) begin @(negedge clk); hi += load_en; end
    chk("R8 suspended while off", hi, 0);
    chk("R8 aborted test keeps warn", warn, 0);

    // sweep failing reading over every window index
    for (int p = 0; p < WIN; p++) begin
      bt = 1'b1;                 // sampled while still off: ignored
      pg = 1'b1;
      count_low(n);
      chk("R1 start", n, 1);
      run_window(4'(1 << p), len);
      chk("R3 window", len, WIN);
      chk($sformatf("R5 fail at index %0d", p), warn, 1);
      count_low(n);
      chk("R4 restart at power-up", n, IVL);
      run_window(4'b0000, len);
      chk("R6 periodic pass keeps warn", warn, 1);
      power_cycle();
      count_low(n);
      chk("R1 start with warn active", n, 1);
      run_window(4'b0000, len);
      chk("R7 power-up pass clears", warn, 0);
      bt = 1'b1;
      cycles(3);
      bt = 1'b0;
      cycles(1);
      chk("R5 reading outside window ignored", warn, 0);
      pg = 1'b0;
      cycles(3);
    end

    // periodic test failing, then power-up test failing
    pg = 1'b1;
    count_low(n);
    run_window(4'b0000, len);
    count_low(n);
    run_window(4'b0110, len);
    chk("R5 periodic fail sets warn", warn, 1);
    power_cycle();
    pg = 1'b0;
    cycles(3);
    chk("R8 warn held while off", warn, 1);
    pg = 1'b1;
    count_low(n);
    run_window(4'b0001, len);
    chk("R7 power-up fail keeps warn", warn, 1);
    power_cycle();
    count_low(n);
    run_window(4'b0000, len);
    chk("R7 later pass clears", warn, 0);

    done = 1'b1;
    finish_run();
  end
endmodule